// File: doc/BRIEF.md
# Prioritized Host Interrupt Request and Poll Responder

This block sits on a peripheral card and decides when the card asks its host for attention. An 8-bit enable mask, loaded by the card's controller, is compared every cycle with a set of live condition levels: a service request seen on the instrument bus, the card being the active controller, the active talker or an active listener, the inbound data register being full, the outbound data register being empty, and a summary of error, device-clear and end-of-message events. Any enabled condition that is true latches a pending interrupt, and the pending interrupt stays latched until the host reads the card's interrupt-acknowledge register.

The card's 4-bit select code picks which of two host request lines carries the pending interrupt. Codes 0 to 7 use the low-priority line and codes 8 to 15 use the high-priority line. When the host runs an interrupt poll, both request lines are withdrawn. The card answers the poll by pulling one host data line low, chosen by the low three bits of its select code. It answers only when the host's poll address bit matches the top bit of the select code. The block also drives the card's status line. An interrupt from most causes clears the status line. A status-read sequence sets it again.

Top module: `host_irq_poll`

## Requirements
- R1: A pending interrupt drives `irq_lo` when `sel_code` is 0 to 7 and `irq_hi` when `sel_code` is 8 to 15. The two lines are never high together. Each line follows `sel_code` one clock edge after it changes.
- R2: A request line is high only while an interrupt is pending and `poll_n` is high. One clock edge after `poll_n` goes low, both request lines are low.
- R3: `dbus_pull` is a vector in which bit i set means host data line i is pulled low. One edge after `poll_n` is sampled low with `poll_addr_msb` equal to `sel_code[3]`, exactly bit `sel_code[2:0]` of `dbus_pull` is set. Otherwise `dbus_pull` is all zero.
- R4: The enable mask maps its bits to conditions as follows. Bit 7 enables `srq_in`, bit 6 `ctl_in`, bit 5 `tlk_in`, bit 4 `lsn_in`, bit 3 `in_full`, bit 2 `out_empty` and bit 1 `evt_in`. Bit 0 is a mode bit that lets an event interrupt clear status. An enabled condition that is high sets the pending interrupt, and the request line rises two edges later.
- R5: Writing the mask while an enabled condition is already high raises the request line three clock edges after the write cycle.
- R6: An interrupt caused by `srq_in`, `ctl_in`, `tlk_in` or `lsn_in` clears `status_ok`. One caused by `in_full` leaves `status_ok` unchanged. One caused by `evt_in` clears `status_ok` only when mask bit 0 is set.
- R7: Only the first `out_empty` interrupt after a mask write clears `status_ok`. Later `out_empty` interrupts leave it set until the mask is written again.
- R8: A pending interrupt stays pending after its condition goes away. Only a pulse on `r6_rd` removes it.
- R9: A pulse on `status_rd` sets `status_ok` one edge later. `status_ok` then stays set while no new interrupt is raised.
- R10: After reset, both request lines and `dbus_pull` are low, `status_ok` is high and the mask is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_code | input | 4 | Card select code |
| mask_wr | input | 1 | Load the enable mask from `mask_din` |
| mask_din | input | 8 | New enable mask |
| srq_in | input | 1 | Service request seen on the bus |
| ctl_in | input | 1 | Card is active controller |
| tlk_in | input | 1 | Card is active talker |
| lsn_in | input | 1 | Card is active listener |
| in_full | input | 1 | Inbound data register full |
| out_empty | input | 1 | Outbound data register empty |
| evt_in | input | 1 | Error, device-clear or end-of-message event |
| r6_rd | input | 1 | Host read of the interrupt-acknowledge register |
| status_rd | input | 1 | Host status-read sequence |
| poll_n | input | 1 | Host interrupt poll, low active |
| poll_addr_msb | input | 1 | Host poll address top bit |
| irq_lo | output | 1 | Low-priority request line |
| irq_hi | output | 1 | High-priority request line |
| dbus_pull | output | 8 | Host data lines to pull low during a poll |
| status_ok | output | 1 | Card status line |

## Verification
A stuck or early-clearing pending latch shows up at a request line within two edges. The check is a withdrawn request after a condition drops, or a request that survives an acknowledge read. A wrong first-output-empty flag shows only at `status_ok`, one edge after the second output-empty interrupt, or after the first one that follows a mask write. A misrouted select code shows at the request pair or at `dbus_pull` one edge after the code or the poll line changes. For that reason every select code is tried with both poll address values.

// File: rtl/hip_pkg.sv
package hip_pkg;
  // Mask bit positions; the controller firmware relies on this layout.
  localparam int MASK_W   = 8;
  localparam int B_EVTCLR = 0;
  localparam int B_EVT    = 1;
  localparam int B_OE     = 2;
  localparam int B_INF    = 3;
  localparam int B_LSN    = 4;
  localparam int B_TLK    = 5;
  localparam int B_CTL    = 6;
  localparam int B_SRQ    = 7;
  // Causes whose interrupt always clears status.
  localparam logic [MASK_W-1:0] CLR_ALWAYS =
    (MASK_W'(1) << B_SRQ) | (MASK_W'(1) << B_CTL) |
    (MASK_W'(1) << B_TLK) | (MASK_W'(1) << B_LSN);
endpackage

// File: rtl/hip_cond_match.sv
module hip_cond_match
  import hip_pkg::*;
(
  input  logic [MASK_W-1:0] mask_q,
  input  logic [MASK_W-1:1] cond,
  output logic              any_hit,
  output logic              clr_hit,
  output logic              oe_hit
);
  logic [MASK_W-1:0] hit;

  assign hit[0] = 1'b0;
  for (genvar i = 1; i < MASK_W; i++) begin : g_hit
    assign hit[i] = mask_q[i] & cond[i];
  end

  always_comb begin
    any_hit = |hit;
    oe_hit  = hit[B_OE];
    clr_hit = (|(hit & CLR_ALWAYS)) | (hit[B_EVT] & mask_q[B_EVTCLR]);
  end
endmodule

// File: rtl/hip_irq_state.sv
module hip_irq_state
  import hip_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_din,
  input  logic              any_hit,
  input  logic              clr_hit,
  input  logic              oe_hit,
  input  logic              r6_rd,
  input  logic              status_rd,
  output logic [MASK_W-1:0] mask_q,
  output logic              pend_q,
  output logic              status_q
);
  logic oe_done_q;
  logic new_irq;
  logic clr_status;

  always_comb begin
    new_irq    = any_hit & (~pend_q | r6_rd);
    clr_status = new_irq & (clr_hit | (oe_hit & ~oe_done_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      pend_q    <= 1'b0;
      status_q  <= 1'b1;
      oe_done_q <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_din;
      pend_q <= (pend_q & ~r6_rd) | any_hit;
      if (clr_status)     status_q <= 1'b0;
      else if (status_rd) status_q <= 1'b1;
      if (mask_wr)                oe_done_q <= 1'b0;
      else if (new_irq && oe_hit) oe_done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/hip_poll_drive.sv
module hip_poll_drive #(
  parameter int SEL_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [SEL_W-1:0]          sel_code,
  input  logic                      poll_n,
  input  logic                      poll_addr_msb,
  input  logic                      pend_q,
  output logic                      irq_lo,
  output logic                      irq_hi,
  output logic [2**(SEL_W-1)-1:0]   dbus_pull
);
  localparam int LINES = 2**(SEL_W-1);
  logic hi_range;
  logic answer;

  always_comb begin
    hi_range = sel_code[SEL_W-1];
    answer   = ~poll_n & (poll_addr_msb == hi_range);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= pend_q & poll_n & ~hi_range;
      irq_hi <= pend_q & poll_n & hi_range;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) dbus_pull[i] <= 1'b0;
      else     dbus_pull[i] <= answer & (sel_code[SEL_W-2:0] == (SEL_W-1)'(i));
    end
  end
endmodule

// File: rtl/host_irq_poll.sv
module host_irq_poll
  import hip_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SEL_W-1:0]        sel_code,
  input  logic                    mask_wr,
  input  logic [MASK_W-1:0]       mask_din,
  input  logic                    srq_in,
  input  logic                    ctl_in,
  input  logic                    tlk_in,
  input  logic                    lsn_in,
  input  logic                    in_full,
  input  logic                    out_empty,
  input  logic                    evt_in,
  input  logic                    r6_rd,
  input  logic                    status_rd,
  input  logic                    poll_n,
  input  logic                    poll_addr_msb,
  output logic                    irq_lo,
  output logic                    irq_hi,
  output logic [2**(SEL_W-1)-1:0] dbus_pull,
  output logic                    status_ok
);
  logic [MASK_W-1:1] cond;
  logic [MASK_W-1:0] mask_q;
  logic any_hit, clr_hit, oe_hit, pend_q;

  always_comb begin
    cond        = '0;
    cond[B_SRQ] = srq_in;
    cond[B_CTL] = ctl_in;
    cond[B_TLK] = tlk_in;
    cond[B_LSN] = lsn_in;
    cond[B_INF] = in_full;
    cond[B_OE]  = out_empty;
    cond[B_EVT] = evt_in;
  end

  hip_cond_match u_match (
    .mask_q (mask_q), .cond (cond),
    .any_hit(any_hit), .clr_hit(clr_hit), .oe_hit(oe_hit)
  );

  hip_irq_state u_state (
    .clk(clk), .rst(rst), .mask_wr(mask_wr), .mask_din(mask_din),
    .any_hit(any_hit), .clr_hit(clr_hit), .oe_hit(oe_hit),
    .r6_rd(r6_rd), .status_rd(status_rd),
    .mask_q(mask_q), .pend_q(pend_q), .status_q(status_ok)
  );

  hip_poll_drive #(.SEL_W(SEL_W)) u_poll (
    .clk(clk), .rst(rst), .sel_code(sel_code), .poll_n(poll_n),
    .poll_addr_msb(poll_addr_msb), .pend_q(pend_q),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .dbus_pull(dbus_pull)
  );
endmodule

// File: rtl/host_irq_poll_chk.sv
module host_irq_poll_chk #(
  parameter int SEL_W = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic [SEL_W-1:0]        sel_code,
  input logic                    poll_n,
  input logic                    irq_lo,
  input logic                    irq_hi,
  input logic [2**(SEL_W-1)-1:0] dbus_pull
);
  assert_req_mutex_R1: assert property (@(posedge clk) disable iff (rst)
    !(irq_lo && irq_hi));

  assert_lo_range_R1: assert property (@(posedge clk) disable iff (rst)
    (poll_n && !sel_code[SEL_W-1]) |=> !irq_hi);

  assert_poll_blocks_req_R2: assert property (@(posedge clk) disable iff (rst)
    !poll_n |=> (!irq_lo && !irq_hi));

  assert_pull_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dbus_pull));

  assert_no_pull_idle_R3: assert property (@(posedge clk) disable iff (rst)
    poll_n |=> (dbus_pull == '0));
endmodule

bind host_irq_poll host_irq_poll_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .sel_code(sel_code), .poll_n(poll_n),
  .irq_lo(irq_lo), .irq_hi(irq_hi), .dbus_pull(dbus_pull)
);

// File: tb/tb_host_irq_poll.sv
module tb_host_irq_poll;
  logic clk = 0;
  logic rst = 1;
  logic [3:0] sel_code = 0;
  logic mask_wr = 0;
  logic [7:0] mask_din = 0;
  logic srq_in = 0, ctl_in = 0, tlk_in = 0, lsn_in = 0;
  logic in_full = 0, out_empty = 0, evt_in = 0;
  logic r6_rd = 0, status_rd = 0, poll_n = 1, poll_addr_msb = 0;
  logic irq_lo, irq_hi, status_ok;
  logic [7:0] dbus_pull;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  host_irq_poll dut (.*);

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_conds(logic [7:1] v);
    srq_in = v[7]; ctl_in = v[6]; tlk_in = v[5]; lsn_in = v[4];
    in_full = v[3]; out_empty = v[2]; evt_in = v[1];
  endtask

  task automatic wr_mask(logic [7:0] m);
    mask_din = m; mask_wr = 1; step(1); mask_wr = 0;
  endtask

  task automatic ack();
    r6_rd = 1; step(1); r6_rd = 0;
  endtask

  task automatic sread();
    status_rd = 1; step(1); status_rd = 0;
  endtask

  task automatic clean();
    set_conds(7'd0); wr_mask(8'h00); ack(); sread(); step(1);
  endtask

  initial begin
    step(2); rst = 0; step(1);
    // R10 reset state
    check("R10 irq_lo", irq_lo, 0);
    check("R10 irq_hi", irq_hi, 0);
    check("R10 pull", dbus_pull, 0);
    check("R10 status", status_ok, 1);
    set_conds(7'b1111111); step(3);
    check("R10 mask zero no irq", irq_lo | irq_hi, 0);
    set_conds(7'd0); step(1);

    // R1 R2 R3 sweep over select codes and poll address
    set_conds(7'b1000000); wr_mask(8'h80); step(2);
    for (int s = 0; s < 16; s++) begin
      poll_n = 1; sel_code = 4'(s); step(1);
      check("R1 irq_lo", irq_lo, (s < 8) ? 1 : 0);
      check("R1 irq_hi", irq_hi, (s >= 8) ? 1 : 0);
      check("R3 no pull idle", dbus_pull, 0);
      poll_n = 0;
      for (int a = 0; a < 2; a++) begin
        poll_addr_msb = a[0]; step(1);
        check("R2 poll hides req", irq_lo | irq_hi, 0);
        check("R3 pull", dbus_pull,
              (a == s / 8) ? (32'd1 << (s % 8)) : 32'd0);
      end
    end
    poll_n = 1; sel_code = 4'd3; step(1);

    // R8 hold after condition drops, clear on read
    set_conds(7'd0); step(4);
    check("R8 held", irq_lo, 1);
    ack(); step(1);
    check("R8 cleared", irq_lo, 0);
    clean();

    // R5 mask write with condition already true
    tlk_in = 1; step(4);
    check("R5 masked", irq_lo, 0);
    wr_mask(8'h20); step(1);
    check("R5 not yet", irq_lo, 0);
    step(1);
    check("R5 raised", irq_lo, 1);
    clean();

    // R4 R6 each condition with mode bit 0 both ways
    for (int b = 1; b < 8; b++) begin
      for (int m = 0; m < 2; m++) begin
        logic exp_st;
        set_conds(7'(1 << (b - 1)));
        wr_mask(8'((1 << b) | m)); step(2);
        check("R4 cond irq", irq_lo, 1);
        if (b == 3) exp_st = 1;
        else if (b == 1) exp_st = (m == 0);
        else exp_st = 0;
        check("R6 status effect", status_ok, exp_st);
        clean();
        check("R9 status restored", status_ok, 1);
      end
    end

    // R7 only first output-empty interrupt clears status
    out_empty = 1; wr_mask(8'h04); step(2);
    check("R7 first clears", status_ok, 0);
    sread(); step(1);
    check("R9 status set", status_ok, 1);
    out_empty = 0; ack(); step(1);
    check("R8 out_empty acked", irq_lo, 0);
    out_empty = 1; step(2);
    check("R7 second irq", irq_lo, 1);
    check("R7 second keeps status", status_ok, 1);
    out_empty = 0; ack(); wr_mask(8'h04); step(1);
    out_empty = 1; step(2);
    check("R7 rearmed clears", status_ok, 0);
    clean();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule